// File: doc/BRIEF.md
# Triple Watchdog Timer Bank

This block holds three independent 16-bit watchdog counters behind a small synchronous register bus. All three counters count down on one shared tick. The tick comes from a prescaler that divides the system clock down to the watchdog time unit. Software arms a counter by writing its reload value. It keeps the counter alive by reading the live count, because that read copies the reload value back into the counter. If software stops servicing a counter, the counter reaches zero and acts. Counter 0 raises a level interrupt. Counter 1 pulses a processor-only reset. Counter 2 pulses a whole-system reset.

A shared three-bit gate register can silence each counter's action. A silenced counter still counts down and still reports expiry in its status byte. Halfword registers are stored in the opposite byte order to the bus, so every halfword transfer swaps its two bytes. Each counter has a 16-byte window of registers:

- live count at offset 0 (halfword)
- reload value at offset 4 (halfword)
- status at offset 8 (byte)

The gate register is at byte address 0x30. Byte address 0x34 is a reserved status byte.

Top module: `tri_wdog_bank`

## Requirements
- R1: After reset, every live count and every reload value is 1 (bus reads 0x0100), every status byte is 0, the gate register is 0, and irq_o, cpu_rst_o and sys_rst_o are low.
- R2: A halfword access swaps bytes: bus_wdata[15:8] goes to the stored low byte, and stored bits [7:0] come back on bus_rdata[15:8]. For example, writing 0x0300 arms a count of 3 ticks.
- R3: A halfword write to a reload register (window offset 4) loads both the reload value and the live count, sets running (status bit 0) and clears expired (status bit 1). Reading the reload register does not change the count.
- R4: A running count drops by exactly one per prescaler tick, and a tick comes once every TICK_DIV clock cycles.
- R5: A halfword read of the live count (window offset 0) returns the value before the access and reloads the count from the reload register. This read is the keepalive.
- R6: When a running count reaches zero, the count stays at 0, running clears and expired sets. A later keepalive read does not restart the counter.
- R7: When counter 0 expires with gate bit 0 clear, irq_o goes high and stays high until the next write to counter 0's reload register.
- R8: When counter 1 or counter 2 expires with its gate bit clear, cpu_rst_o or sys_rst_o (respectively) goes high for exactly RST_PULSE cycles, once per expiry.
- R9: A byte write to address 0x30 loads the gate bits [2:0]. When a counter's gate bit is 1, its expiry leaves its output low, but the counter still counts and still reports expired.
- R10: The following accesses have no effect: writes to a live count or a status byte, byte-sized accesses to halfword registers, and halfword-sized accesses to byte registers. Such reads return 0, as do status bits 7:2 and address 0x34. bus_rdata changes only on a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data (byte data on bits 7:0) |
| bus_rdata | output | 16 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Counter 0 expiry interrupt, level |
| cpu_rst_o | output | 1 | Counter 1 processor reset pulse |
| sys_rst_o | output | 1 | Counter 2 system reset pulse |

## Verification
A wrong count or reload state shows up in the next live-count read. Reads spaced a whole number of tick periods apart must differ by exactly that many ticks, so a missed or extra decrement appears within one tick period. Broken expiry state shows up as a status byte that disagrees with the elapsed time, as an interrupt that drops or never rises, or as a reset pulse of the wrong width. All of these are visible within a few cycles of the final tick. A wrong byte order shows up both in the read value and in an expiry time off by a factor of about 256.

// File: rtl/tri_wdog_pkg.sv
package tri_wdog_pkg;

    localparam int unsigned HW_W = 16;
    localparam int unsigned NCH  = 3;

    typedef enum logic {ACT_LEVEL = 1'b0, ACT_PULSE = 1'b1} act_kind_e;

    localparam logic [3:0] OFF_CNT  = 4'h0;
    localparam logic [3:0] OFF_LIM  = 4'h4;
    localparam logic [3:0] OFF_STAT = 4'h8;
    localparam logic [5:0] ADDR_GATE = 6'h30;
    localparam logic [5:0] ADDR_RSV  = 6'h34;

    function automatic logic [HW_W-1:0] swap16(input logic [HW_W-1:0] v);
        return {v[7:0], v[15:8]};
    endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int unsigned DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = (div_q == LAST);

    assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
    assert_div_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (div_q == '0));

endmodule

// File: rtl/wdog_chan.sv
module wdog_chan
    import tri_wdog_pkg::*;
#(
    parameter act_kind_e   KIND      = ACT_LEVEL,
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            lim_wr_i,
    input  logic [HW_W-1:0] lim_val_i,
    input  logic            cnt_rd_i,
    input  logic            act_en_i,
    output logic [HW_W-1:0] cnt_o,
    output logic [HW_W-1:0] lim_o,
    output logic            run_o,
    output logic            exp_o,
    output logic            act_o
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [HW_W-1:0] cnt;
        logic [HW_W-1:0] lim;
        logic            run;
        logic            exp;
        logic            lvl;
        logic [PW-1:0]   pcnt;
    } chan_st_t;

    chan_st_t d, q;

    always_comb begin
        d = q;
        if (q.pcnt != '0) d.pcnt = q.pcnt - 1'b1;
        if (lim_wr_i) begin
            d.lim = lim_val_i;
            d.cnt = lim_val_i;
            d.run = 1'b1;
            d.exp = 1'b0;
            d.lvl = 1'b0;
        end else begin
            if (q.run && tick_i) begin
                if (q.cnt <= HW_W'(1)) begin
                    d.cnt = '0;
                    d.run = 1'b0;
                    d.exp = 1'b1;
                    if (act_en_i) begin
                        d.lvl  = 1'b1;
                        d.pcnt = PW'(PULSE_LEN);
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            if (cnt_rd_i) d.cnt = q.lim;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{cnt: HW_W'(1), lim: HW_W'(1), run: 1'b0, exp: 1'b0,
                   lvl: 1'b0, pcnt: '0};
        end else begin
            q <= d;
        end
    end

    assign cnt_o = q.cnt;
    assign lim_o = q.lim;
    assign run_o = q.run;
    assign exp_o = q.exp;

    generate
        if (KIND == ACT_LEVEL) begin : g_level
            assign act_o = q.lvl;
        end else begin : g_pulse
            assign act_o = (q.pcnt != '0);
        end
    endgenerate

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr_i |=> (run_o && !exp_o && cnt_o == $past(lim_val_i)));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd_i && !lim_wr_i) |=> (cnt_o == $past(lim_o)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !tick_i && !lim_wr_i && !cnt_rd_i) |=> $stable(cnt_o));
    assert_exp_not_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_o && exp_o));
    assert_act_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_o) |-> $past(act_en_i));

endmodule

// File: rtl/tri_wdog_bank.sv
module tri_wdog_bank
    import tri_wdog_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 25_000_000,
    parameter int unsigned RST_PULSE = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [5:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq_o,
    output logic        cpu_rst_o,
    output logic        sys_rst_o
);
    typedef struct packed {
        logic [NCH-1:0]  gate;
        logic [HW_W-1:0] rdata;
    } bank_st_t;

    bank_st_t d, q;

    logic            tick;
    logic [1:0]      win;
    logic [3:0]      off;
    logic [NCH-1:0]  lim_wr, cnt_rd, run_w, exp_w, act_w;
    logic [HW_W-1:0] cnt_w [NCH];
    logic [HW_W-1:0] lim_w [NCH];

    assign win = bus_addr[5:4];
    assign off = bus_addr[3:0];

    wdog_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign lim_wr[i] = bus_sel && bus_wr && bus_half
                               && (win == 2'(i)) && (off == OFF_LIM);
            assign cnt_rd[i] = bus_sel && !bus_wr && bus_half
                               && (win == 2'(i)) && (off == OFF_CNT);
            wdog_chan #(
                .KIND      ((i == 0) ? ACT_LEVEL : ACT_PULSE),
                .PULSE_LEN (RST_PULSE)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick),
                .lim_wr_i  (lim_wr[i]),
                .lim_val_i (swap16(bus_wdata)),
                .cnt_rd_i  (cnt_rd[i]),
                .act_en_i  (!q.gate[i]),
                .cnt_o     (cnt_w[i]),
                .lim_o     (lim_w[i]),
                .run_o     (run_w[i]),
                .exp_o     (exp_w[i]),
                .act_o     (act_w[i])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        if (bus_sel && bus_wr && !bus_half && bus_addr == ADDR_GATE) begin
            d.gate = bus_wdata[NCH-1:0];
        end
        if (bus_sel && !bus_wr) begin
            d.rdata = '0;
            for (int i = 0; i < NCH; i++) begin
                if (win == 2'(i)) begin
                    if (bus_half && off == OFF_CNT)       d.rdata = swap16(cnt_w[i]);
                    else if (bus_half && off == OFF_LIM)  d.rdata = swap16(lim_w[i]);
                    else if (!bus_half && off == OFF_STAT) d.rdata = {14'd0, exp_w[i], run_w[i]};
                end
            end
            if (!bus_half && bus_addr == ADDR_GATE) d.rdata = {13'd0, q.gate};
            if (!bus_half && bus_addr == ADDR_RSV)  d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{gate: '0, rdata: '0};
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign irq_o     = act_w[0];
    assign cpu_rst_o = act_w[1];
    assign sys_rst_o = act_w[2];

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
    assert_one_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lim_wr, cnt_rd}));

endmodule

// File: tb/tb_tri_wdog_bank.sv
module tb_tri_wdog_bank;
    localparam int DIV = 8;
    localparam int PL  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o;

    int nchk = 0, nfail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;
    int          w1 = 0, w2 = 0, last1 = 0, last2 = 0, np1 = 0, np2 = 0;

    always #2 clk = ~clk;

    tri_wdog_bank #(.TICK_DIV(DIV), .RST_PULSE(PL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
        .sys_rst_o(sys_rst_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // monitor: compare read data against scoreboard
    always @(posedge clk) pend <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (pend) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata === e, t, int'(bus_rdata), int'(e));
        end
    end

    // reset pulse width monitor
    always @(posedge clk) begin
        if (cpu_rst_o) w1++;
        else if (w1 != 0) begin last1 = w1; np1++; w1 = 0; end
        if (sys_rst_o) w2++;
        else if (w2 != 0) begin last2 = w2; np2++; w2 = 0; end
    end

    task automatic acc(input bit wr, input bit half, input logic [5:0] a, input logic [15:0] v);
        bus_sel = 1'b1; bus_wr = wr; bus_half = half; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input bit half, input logic [5:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc(1'b0, half, a, 16'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            rd(1'b1, 6'(i*16),     16'h0100, "R1 count");
            rd(1'b1, 6'(i*16 + 4), 16'h0100, "R1 reload");
            rd(1'b0, 6'(i*16 + 8), 16'h0000, "R1 status");
        end
        rd(1'b0, 6'h30, 16'h0000, "R1 gate");
        check(!irq_o && !cpu_rst_o && !sys_rst_o, "R1 outputs", int'({irq_o, cpu_rst_o, sys_rst_o}), 0);

        // R3 / R4 / R5 on counter 0, count 10
        acc(1'b1, 1'b1, 6'h04, 16'h0A00);
        rd(1'b1, 6'h00, 16'h0A00, "R3 load");
        idle(2*DIV);
        rd(1'b1, 6'h00, 16'h0800, "R4 two ticks");
        idle(DIV);
        rd(1'b1, 6'h00, 16'h0900, "R5 reload then one tick");
        rd(1'b1, 6'h04, 16'h0A00, "R3 reload read");
        idle(DIV-1);
        rd(1'b1, 6'h00, 16'h0900, "R3 reload read no side effect");
        rd(1'b0, 6'h08, 16'h0001, "R3 running");

        // R2 / R6 / R7 expiry of counter 0 with count 3
        acc(1'b1, 1'b1, 6'h04, 16'h0300);
        idle(3*DIV + 3);
        check(irq_o === 1'b1, "R7 irq on expiry", int'(irq_o), 1);
        rd(1'b0, 6'h08, 16'h0002, "R6 R2 expired after 3 ticks");
        rd(1'b1, 6'h00, 16'h0000, "R6 count held at zero");
        idle(4*DIV);
        rd(1'b0, 6'h08, 16'h0002, "R6 keepalive does not restart");
        check(irq_o === 1'b1, "R7 irq level held", int'(irq_o), 1);
        acc(1'b1, 1'b1, 6'h04, 16'hFFFF);
        check(irq_o === 1'b0, "R7 irq cleared by reload write", int'(irq_o), 0);

        // R5 keepalive on counter 1, R8 pulse
        acc(1'b1, 1'b1, 6'h14, 16'h0400);
        rd(1'b1, 6'h10, 16'h0400, "R5 first");
        for (int k = 0; k < 6; k++) begin
            idle(2*DIV);
            rd(1'b1, 6'h10, 16'h0200, "R5 keepalive");
        end
        check(np1 == 0, "R5 no pulse while serviced", np1, 0);
        rd(1'b0, 6'h18, 16'h0001, "R5 still running");
        idle(4*DIV + 3 + PL);
        check(np1 == 1, "R8 cpu pulse count", np1, 1);
        check(last1 == PL, "R8 cpu pulse width", last1, PL);
        rd(1'b0, 6'h18, 16'h0002, "R8 counter 1 expired");

        // R8 counter 2
        acc(1'b1, 1'b1, 6'h24, 16'h0200);
        idle(2*DIV + 3 + PL);
        check(np2 == 1, "R8 sys pulse count", np2, 1);
        check(last2 == PL, "R8 sys pulse width", last2, PL);

        // R2 byte order: 0x0001 on the bus is 256 ticks
        acc(1'b1, 1'b1, 6'h24, 16'h0001);
        idle(4*DIV);
        rd(1'b0, 6'h28, 16'h0001, "R2 long count still running");
        rd(1'b1, 6'h24, 16'h0001, "R2 reload read swapped back");

        // R9 gating
        acc(1'b1, 1'b0, 6'h30, 16'h0007);
        rd(1'b0, 6'h30, 16'h0007, "R9 gate readback");
        acc(1'b1, 1'b1, 6'h04, 16'h0200);
        acc(1'b1, 1'b1, 6'h14, 16'h0200);
        acc(1'b1, 1'b1, 6'h24, 16'h0200);
        idle(2*DIV + 3 + PL);
        check(irq_o === 1'b0, "R9 irq gated", int'(irq_o), 0);
        check(np1 == 1 && np2 == 1, "R9 resets gated", np1 + np2, 2);
        rd(1'b0, 6'h08, 16'h0002, "R9 counter 0 expired");
        rd(1'b0, 6'h18, 16'h0002, "R9 counter 1 expired");
        rd(1'b0, 6'h28, 16'h0002, "R9 counter 2 expired");

        // R10 ignored accesses
        acc(1'b1, 1'b1, 6'h10, 16'h0900);
        rd(1'b1, 6'h10, 16'h0000, "R10 count write ignored");
        acc(1'b1, 1'b0, 6'h18, 16'h0001);
        rd(1'b0, 6'h18, 16'h0002, "R10 status write ignored");
        acc(1'b1, 1'b0, 6'h14, 16'h0005);
        rd(1'b0, 6'h18, 16'h0002, "R10 byte reload write ignored");
        rd(1'b1, 6'h18, 16'h0000, "R10 halfword status read");
        rd(1'b0, 6'h34, 16'h0000, "R10 reserved byte");
        idle(3);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule